// File: doc/BRIEF.md
# Image Sensor Sample Region Tagger

This block follows the samples that leave an interline image sensor with field readout and marks where each one sits in the sensor's layout. An upstream sync generator supplies a pixel-rate enable, a one-cycle line-start pulse and a field flag. From these the block keeps a column count within the line and a row count within the field. It labels every sample with exactly one of four regions: dummy, optical black, effective or idle.

Each line begins with the horizontal register's dummy bits. After these come a short leading black margin, the effective pixels and a long trailing black margin. Any samples that arrive after that, up to the next line-start, are idle. Vertically, a field has a short run of black rows, then the effective rows, then a trailing black row. The even field has one extra dummy row in front of all of these. Two strobes are derived from the region tags and feed later stages. The first is a black-reference strobe for a clamp, raised on trailing black pixels of effective rows. The second is a capture strobe, raised on effective pixels.

All results are registered. They appear one clock after the enabled sample they describe, together with a valid bit.

Top module: `ccd_region_tagger`

## Requirements
- R1: The sample taken in the cycle of a line-start pulse, or the first enabled sample after a line-start, is column 0. Each further enabled sample adds one to the column. The column stops at the line total (833 by default) and does not wrap. Cycles without the pixel enable do not advance it.
- R2: A line-start starts a new field when it is the first line-start after reset, or when the field input (1 = even, 0 = odd) differs from the held flag. A new field resets the row to 0 and loads the held flag. Any other line-start adds one to the row, which stops at 255. The held flag, `o_field`, changes only in the cycle after a line-start.
- R3: Columns 0 to 21 are tagged dummy on every row that is not idle.
- R4: Columns 22 to 24 and 793 to 832 are tagged optical black on rows that are neither dummy nor idle.
- R5: In an even field, row 0 is a dummy row, and its columns below 833 are tagged dummy. An odd field has no dummy row.
- R6: Rows 0 to 5 and row 253 of an odd field are optical-black rows. So are rows 1 to 6 and row 254 of an even field. Their columns 25 to 792 are tagged optical black.
- R7: Columns 25 to 792 on the effective rows are tagged effective. The effective rows are 6 to 252 in an odd field and 7 to 253 in an even field.
- R8: A sample is tagged idle if its column is 833 or more, if its row is past the trailing black row (odd 254 and up, even 255), or if no line-start has been seen since reset.
- R9: `o_region` is always one-hot: bit 0 dummy, bit 1 optical black, bit 2 effective, bit 3 idle.
- R10: `o_clamp` is high only for columns 793 to 832 on effective rows.
- R11: `o_capture` is high exactly when the sample is tagged effective.
- R12: Every enabled sample produces exactly one result one clock later, marked by `o_vld`. In a cycle without the enable, `o_vld` is low in the next cycle and the column, row and tags hold their values.
- R13: While the synchronous reset is high, `o_vld`, `o_clamp`, `o_capture`, `o_field`, `o_col` and `o_row` go to 0, and `o_region` goes to idle (4'b1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | One sensor sample in this cycle |
| line_start | input | 1 | Marks the start of a line; the sample in this cycle, if any, is column 0 |
| field_in | input | 1 | Field flag from the sync generator, 1 = even |
| o_vld | output | 1 | The outputs describe the sample from the previous cycle |
| o_col | output | CW (10) | Column of that sample |
| o_row | output | RW (8) | Row of that sample within its field |
| o_region | output | 4 | One-hot region tag |
| o_clamp | output | 1 | Black-reference strobe |
| o_capture | output | 1 | Effective-pixel strobe |
| o_field | output | 1 | Held field flag |

## Verification
Each enabled sample's results are due exactly one clock after the edge that samples it. The held field flag is due one clock after a line-start, even when that line-start carries no sample. Inputs change on the falling edge. For each enabled sample, the driver queues the expected column, row, tag, strobes and flag, computed from the layout rules above. The monitor samples one nanosecond after the next rising edge and matches every valid result against the front of the queue. A result with no queued entry, or an entry still in the queue at the end, is counted as a failure.

// File: rtl/ccd_tag_pkg.sv
`timescale 1ns/1ps
package ccd_tag_pkg;
  typedef enum logic [3:0] {
    REG_DUMMY = 4'b0001,
    REG_OB    = 4'b0010,
    REG_ACT   = 4'b0100,
    REG_IDLE  = 4'b1000
  } region_e;

  typedef enum logic [1:0] {
    Z_DUMMY = 2'd0,
    Z_OB    = 2'd1,
    Z_ACT   = 2'd2,
    Z_IDLE  = 2'd3
  } zone_e;
endpackage

// File: rtl/ccd_hpos.sv
`timescale 1ns/1ps
module ccd_hpos
  import ccd_tag_pkg::*;
#(
  parameter int H_DUM = 22,
  parameter int H_OBF = 3,
  parameter int H_EFF = 768,
  parameter int H_OBR = 40,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          line_start,
  output logic [CW-1:0] cur_col,
  output zone_e         zone,
  output logic          rear
);
  localparam int HTOT = H_DUM + H_OBF + H_EFF + H_OBR;
  localparam logic [CW-1:0] C_OBF  = CW'(H_DUM);
  localparam logic [CW-1:0] C_ACT  = CW'(H_DUM + H_OBF);
  localparam logic [CW-1:0] C_OBR  = CW'(H_DUM + H_OBF + H_EFF);
  localparam logic [CW-1:0] C_IDLE = CW'(HTOT);

  logic [CW-1:0] cnt_q;

  // a line-start forces this cycle's sample to column 0
  assign cur_col = line_start ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= C_IDLE;
    else if (pix_en)
      cnt_q <= (cur_col == C_IDLE) ? C_IDLE : cur_col + 1'b1;
    else if (line_start)
      cnt_q <= '0;
  end

  always_comb begin
    rear = 1'b0;
    if (cur_col < C_OBF)       zone = Z_DUMMY;
    else if (cur_col < C_ACT)  zone = Z_OB;
    else if (cur_col < C_OBR)  zone = Z_ACT;
    else if (cur_col < C_IDLE) begin
      zone = Z_OB;
      rear = 1'b1;
    end
    else                       zone = Z_IDLE;
  end
endmodule

// File: rtl/ccd_vpos.sv
`timescale 1ns/1ps
module ccd_vpos
  import ccd_tag_pkg::*;
#(
  parameter int V_OBF = 6,
  parameter int V_EFF = 247,
  parameter int V_OBR = 1,
  parameter int RW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          field_in,
  output logic [RW-1:0] cur_row,
  output logic          cur_even,
  output logic          field_held,
  output zone_e         zone
);
  localparam logic [RW-1:0] R_ACT  = RW'(V_OBF);
  localparam logic [RW-1:0] R_OBR  = RW'(V_OBF + V_EFF);
  localparam logic [RW-1:0] R_IDLE = RW'(V_OBF + V_EFF + V_OBR);
  localparam logic [RW-1:0] R_MAX  = RW'(1 + V_OBF + V_EFF + V_OBR);

  logic          started_q;
  logic          fld_q;
  logic [RW-1:0] row_q;
  logic          new_fld;
  logic [RW-1:0] row_inc;
  logic [RW-1:0] rel;

  assign new_fld  = line_start && (!started_q || (field_in != fld_q));
  assign row_inc  = (row_q == R_MAX) ? R_MAX : row_q + 1'b1;
  assign cur_row  = !line_start ? row_q : (new_fld ? '0 : row_inc);
  assign cur_even = new_fld ? field_in : fld_q;
  // even fields carry one leading dummy row; remove it before decoding
  assign rel      = cur_row - {{(RW-1){1'b0}}, cur_even};
  assign field_held = fld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      fld_q     <= 1'b0;
      row_q     <= '0;
    end else if (line_start) begin
      started_q <= 1'b1;
      fld_q     <= cur_even;
      row_q     <= cur_row;
    end
  end

  always_comb begin
    if (!started_q && !line_start)     zone = Z_IDLE;
    else if (cur_even && cur_row == '0) zone = Z_DUMMY;
    else if (rel < R_ACT)               zone = Z_OB;
    else if (rel < R_OBR)               zone = Z_ACT;
    else if (rel < R_IDLE)              zone = Z_OB;
    else                                zone = Z_IDLE;
  end
endmodule

// File: rtl/ccd_classify.sv
`timescale 1ns/1ps
module ccd_classify
  import ccd_tag_pkg::*;
(
  input  zone_e   hzone,
  input  logic    hrear,
  input  zone_e   vzone,
  output region_e region,
  output logic    clamp,
  output logic    capture
);
  always_comb begin
    if (hzone == Z_IDLE || vzone == Z_IDLE)        region = REG_IDLE;
    else if (hzone == Z_DUMMY || vzone == Z_DUMMY) region = REG_DUMMY;
    else if (hzone == Z_OB || vzone == Z_OB)       region = REG_OB;
    else                                           region = REG_ACT;
    clamp   = (hzone == Z_OB) && hrear && (vzone == Z_ACT);
    capture = (hzone == Z_ACT) && (vzone == Z_ACT);
  end
endmodule

// File: rtl/ccd_region_tagger.sv
`timescale 1ns/1ps
module ccd_region_tagger
  import ccd_tag_pkg::*;
#(
  parameter int H_DUM = 22,
  parameter int H_OBF = 3,
  parameter int H_EFF = 768,
  parameter int H_OBR = 40,
  parameter int V_OBF = 6,
  parameter int V_EFF = 247,
  parameter int V_OBR = 1,
  localparam int CW = $clog2(H_DUM + H_OBF + H_EFF + H_OBR + 1),
  localparam int RW = $clog2(V_OBF + V_EFF + V_OBR + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          line_start,
  input  logic          field_in,
  output logic          o_vld,
  output logic [CW-1:0] o_col,
  output logic [RW-1:0] o_row,
  output logic [3:0]    o_region,
  output logic          o_clamp,
  output logic          o_capture,
  output logic          o_field
);
  logic [CW-1:0] cur_col;
  logic [RW-1:0] cur_row;
  zone_e         hzone, vzone;
  logic          hrear, cur_even, fld_held;
  region_e       region;
  logic          clamp, capture;

  ccd_hpos #(.H_DUM(H_DUM), .H_OBF(H_OBF), .H_EFF(H_EFF), .H_OBR(H_OBR), .CW(CW)) i_hpos (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start),
    .cur_col(cur_col), .zone(hzone), .rear(hrear));

  ccd_vpos #(.V_OBF(V_OBF), .V_EFF(V_EFF), .V_OBR(V_OBR), .RW(RW)) i_vpos (
    .clk(clk), .rst(rst), .line_start(line_start), .field_in(field_in),
    .cur_row(cur_row), .cur_even(cur_even), .field_held(fld_held), .zone(vzone));

  ccd_classify i_cls (
    .hzone(hzone), .hrear(hrear), .vzone(vzone),
    .region(region), .clamp(clamp), .capture(capture));

  logic unused_even;
  assign unused_even = cur_even;
  assign o_field = fld_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld     <= 1'b0;
      o_col     <= '0;
      o_row     <= '0;
      o_region  <= REG_IDLE;
      o_clamp   <= 1'b0;
      o_capture <= 1'b0;
    end else begin
      o_vld <= pix_en;
      if (pix_en) begin
        o_col     <= cur_col;
        o_row     <= cur_row;
        o_region  <= region;
        o_clamp   <= clamp;
        o_capture <= capture;
      end
    end
  end
endmodule

// File: rtl/ccd_region_tagger_chk.sv
`timescale 1ns/1ps
module ccd_region_tagger_chk #(
  parameter int CW = 10,
  parameter int RW = 8,
  parameter int HTOT = 833,
  parameter int C_ACT = 25,
  parameter int C_OBR = 793
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          line_start,
  input logic          o_vld,
  input logic [CW-1:0] o_col,
  input logic [RW-1:0] o_row,
  input logic [3:0]    o_region,
  input logic          o_clamp,
  input logic          o_capture,
  input logic          o_field
);
  p_colmax_r1: assert property (@(posedge clk) disable iff (rst)
    int'(o_col) <= HTOT);

  p_field_r2: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(o_field));

  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(o_region) == 1);

  p_clamp_r10: assert property (@(posedge clk) disable iff (rst)
    o_clamp |-> (o_region == 4'b0010) && (int'(o_col) >= C_OBR) && (int'(o_col) < HTOT));

  p_cap_r11: assert property (@(posedge clk) disable iff (rst)
    o_capture |-> (o_region == 4'b0100) && (int'(o_col) >= C_ACT) && (int'(o_col) < C_OBR));

  p_vld_r12: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> o_vld);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> !o_vld && $stable(o_col) && $stable(o_row) && $stable(o_region));
endmodule

bind ccd_region_tagger ccd_region_tagger_chk #(
  .CW(CW), .RW(RW),
  .HTOT(H_DUM + H_OBF + H_EFF + H_OBR),
  .C_ACT(H_DUM + H_OBF),
  .C_OBR(H_DUM + H_OBF + H_EFF)
) i_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start),
  .o_vld(o_vld), .o_col(o_col), .o_row(o_row), .o_region(o_region),
  .o_clamp(o_clamp), .o_capture(o_capture), .o_field(o_field));

// File: tb/test_ccd_region_tagger.sv
`timescale 1ns/1ps
module test_ccd_region_tagger;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0, line_start = 1'b0, field_in = 1'b0;
  logic o_vld, o_clamp, o_capture, o_field;
  logic [9:0] o_col;
  logic [7:0] o_row;
  logic [3:0] o_region;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccd_region_tagger i_ccd_region_tagger (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start), .field_in(field_in),
    .o_vld(o_vld), .o_col(o_col), .o_row(o_row), .o_region(o_region),
    .o_clamp(o_clamp), .o_capture(o_capture), .o_field(o_field));

  typedef struct {
    int col; int row; logic [3:0] rg; bit clamp; bit cap; bit fld; string tag;
  } exp_t;
  exp_t q[$];

  int m_col = 833, m_row = 0;
  bit m_started = 0, m_held = 0;

  function automatic void check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // expected tag from the layout rules
  function automatic exp_t model(int c, int r, bit ev, bit st);
    exp_t e;
    bit row_idle, row_dum, row_ob, row_act;
    int rel;
    rel = r - (ev ? 1 : 0);
    row_dum = ev && r == 0;
    row_idle = !st || (!row_dum && rel >= 254);
    row_ob = !row_dum && !row_idle && (rel < 6 || rel == 253);
    row_act = !row_dum && !row_idle && !row_ob;
    e.col = c; e.row = r; e.fld = ev;
    if (c >= 833 || row_idle) begin e.rg = 4'b1000; e.tag = "R8"; end
    else if (c < 22)          begin e.rg = 4'b0001; e.tag = "R3"; end
    else if (row_dum)         begin e.rg = 4'b0001; e.tag = "R5"; end
    else if (c < 25 || c >= 793) begin e.rg = 4'b0010; e.tag = "R4"; end
    else if (row_ob)          begin e.rg = 4'b0010; e.tag = "R6"; end
    else                      begin e.rg = 4'b0100; e.tag = "R7"; end
    e.clamp = (c >= 793 && c < 833 && row_act);
    e.cap = (e.rg == 4'b0100);
    return e;
  endfunction

  task automatic drive(bit ls, bit en, bit f);
    @(negedge clk);
    line_start = ls; pix_en = en; field_in = f;
    if (ls) begin
      if (!m_started || f != m_held) begin m_row = 0; m_held = f; end
      else m_row = (m_row >= 255) ? 255 : m_row + 1;
      m_started = 1;
      m_col = 0;
    end
    if (en) begin
      q.push_back(model(m_col, m_row, m_held, m_started));
      m_col = (m_col >= 833) ? 833 : m_col + 1;
    end
  endtask

  task automatic send_line(bit f, int n, bit ls_alone, bit toggle_mid);
    bit fcur;
    fcur = f;
    if (ls_alone) drive(1, 0, f);
    for (int i = 0; i < n; i++) begin
      if (toggle_mid && i == n / 2) fcur = !f;
      drive(i == 0 && !ls_alone, 1, fcur);
      if (i % 7 == 3) drive(0, 0, fcur);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && o_vld) begin
        if (q.size() == 0) check(0, "R12 unexpected result", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (int'(o_col) != e.col)  begin failures++; $display("FAIL R1 col: actual=%0d expected=%0d", o_col, e.col); end
          if (int'(o_row) != e.row)  begin failures++; $display("FAIL R2 row: actual=%0d expected=%0d", o_row, e.row); end
          if (o_field != e.fld)      begin failures++; $display("FAIL R2 field: actual=%0d expected=%0d", o_field, e.fld); end
          if (o_region != e.rg)      begin failures++; $display("FAIL %s region col=%0d row=%0d: actual=%b expected=%b", e.tag, e.col, e.row, o_region, e.rg); end
          if ($countones(o_region) != 1) begin failures++; $display("FAIL R9 onehot: actual=%b expected=one bit", o_region); end
          if (o_clamp != e.clamp)    begin failures++; $display("FAIL R10 clamp col=%0d row=%0d: actual=%0d expected=%0d", e.col, e.row, o_clamp, e.clamp); end
          if (o_capture != e.cap)    begin failures++; $display("FAIL R11 capture col=%0d row=%0d: actual=%0d expected=%0d", e.col, e.row, o_capture, e.cap); end
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(o_vld == 0, "R13 vld", o_vld, 0);
    check(o_region == 4'b1000, "R13 region", o_region, 4'b1000);
    check(o_col == 0 && o_row == 0, "R13 col/row", {o_col, o_row}, 0);
    check(!o_clamp && !o_capture && !o_field, "R13 strobes", {o_clamp, o_capture, o_field}, 0);
    // R8: samples before any line-start
    for (int i = 0; i < 3; i++) drive(0, 1, 0);
    // odd field
    send_line(0, 840, 0, 0);                          // R6 row 0, R1 saturation
    for (int r = 1; r <= 5; r++) send_line(0, 30, 0, 0);
    send_line(0, 840, 0, 0);                          // R7 first effective row, R10
    for (int r = 7; r <= 251; r++) send_line(0, 30, 0, 0);
    send_line(0, 800, 0, 0);                          // last effective row
    send_line(0, 800, 0, 0);                          // row 253 trailing black
    send_line(0, 30, 0, 0);                           // row 254 idle
    send_line(0, 30, 1, 0);                           // row 255, line-start alone
    send_line(0, 30, 0, 1);                           // R2 saturation, mid-line flag toggle
    // even field
    send_line(1, 840, 0, 0);                          // R5 dummy row
    for (int r = 1; r <= 6; r++) send_line(1, 30, 0, 0);
    send_line(1, 840, 0, 0);                          // row 7 effective
    for (int r = 8; r <= 252; r++) send_line(1, 30, 0, 0);
    send_line(1, 800, 0, 0);                          // row 253 effective
    send_line(1, 800, 0, 0);                          // row 254 trailing black
    send_line(1, 30, 0, 0);                           // row 255 idle
    send_line(1, 30, 0, 0);                           // saturated
    // back to odd: restart at row 0
    send_line(0, 40, 1, 0);
    drive(0, 0, 0);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R12 results missing", q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule